// File: doc/BRIEF.md
# Multi-Master I2C Clock Generator with Line Synchronization

This block produces the SCL clock for an I2C master that shares an open-drain, wired-AND clock line with other masters and with slaves that may stretch the clock. It never drives the line high. It only asserts a pull-low request, and it watches the real line level through a small synchronizer to decide when each phase begins. The low and high phase lengths come from two programmable 8-bit counts. A programmed value N gives N+1 system-clock cycles, and a value of 0 behaves like 1.

After the block releases the line, it does not start its high phase until the synchronized line actually reads high. Any other device holding the line low therefore lengthens the low phase. With synchronization enabled, a falling edge seen on the line during the high phase ends that phase at once: the block pulls low itself and starts its low count. The shared clock then has the shortest high time and the longest low time of all the masters. With synchronization disabled, such falling edges are ignored and the high phase always runs to its full count. A one-cycle status pulse marks the start of each low phase and each high phase. Dropping the run control releases the line and parks the block. The next run assertion starts with a low phase.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is active or run_i is 0, scl_pull_o, hi_start_o and lo_start_o are all 0.
- R2: In the cycle after run_i is first sampled as 1, scl_pull_o becomes 1 and lo_start_o pulses for that one cycle.
- R3: A low phase keeps scl_pull_o at 1 for exactly lo_cnt_i+1 cycles, and for 2 cycles when lo_cnt_i is 0.
- R4: After scl_pull_o falls, and if the line is free, hi_start_o pulses in the 4th released cycle. The extra cycles are the two synchronizer stages plus one registered decision.
- R5: A high phase with no contention lasts hi_cnt_i+1 cycles from the hi_start_o pulse (2 when hi_cnt_i is 0). The released interval is therefore hi_cnt_i+4 cycles, and it ends with scl_pull_o rising.
- R6: While another device holds the line low after the block has released it, hi_start_o stays 0 and scl_pull_o stays 0. Once the line is freed, hi_start_o pulses in the 3rd cycle.
- R7: With sync_en_i at 1, a low level that another master drives during the high phase makes scl_pull_o rise, together with lo_start_o, in the 3rd cycle after the line falls.
- R8: With sync_en_i at 0, a low level that another master drives during the high phase has no effect: scl_pull_o rises hi_cnt_i+1 cycles after hi_start_o, the same as without contention.
- R9: hi_start_o and lo_start_o are never 1 in the same cycle. lo_start_o is only 1 while scl_pull_o is 1, and hi_start_o is only 1 while scl_pull_o is 0.
- R10: When run_i is sampled as 0, scl_pull_o is 0 in the next cycle, even in the middle of a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables clock generation; 0 parks the block with the line released |
| sync_en_i | input | 1 | 1 lets external falling edges end the high phase early |
| hi_cnt_i | input | CNT_W | High-phase count N (phase = N+1 cycles, 0 treated as 1) |
| lo_cnt_i | input | CNT_W | Low-phase count N (phase = N+1 cycles, 0 treated as 1) |
| scl_i | input | 1 | Sampled level of the shared SCL line |
| scl_pull_o | output | 1 | 1 requests the open-drain driver to pull SCL low |
| hi_start_o | output | 1 | One-cycle pulse at the start of each high phase |
| lo_start_o | output | 1 | One-cycle pulse at the start of each low phase |

## Verification
The bench uses the default 8-bit count width and two synchronizer stages. This fixes the release-to-high latency at three cycles and the reaction time to an external falling edge at three cycles, so both can be checked exactly. Counts of 0, 1, and values up to 40 reach the zero-as-one rule and the short phases where synchronizer latency matters most. A wide high count of 40 leaves room to see both results of an external falling edge: an early cut with synchronization on, and a full-length phase with it off.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= scl_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= {chain_q[STAGES-2:0], scl_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b1;
        else         prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_sync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             sync_en_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             line_hi_i,
    input  logic             line_fall_i,
    output logic             pull_o,
    output logic             hi_start_o,
    output logic             lo_start_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pull;
        logic             hi_start;
        logic             lo_start;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [CNT_W-1:0] hi_lim, lo_lim;
    logic             hi_done, lo_done, cut_high;

    always_comb begin
        hi_lim   = (hi_cnt_i == '0) ? ONE : hi_cnt_i;
        lo_lim   = (lo_cnt_i == '0) ? ONE : lo_cnt_i;
        hi_done  = (st_q.cnt == hi_lim);
        lo_done  = (st_q.cnt == lo_lim);
        cut_high = sync_en_i & line_fall_i;

        st_d          = st_q;
        st_d.hi_start = 1'b0;
        st_d.lo_start = 1'b0;

        if (!run_i) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.pull  = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase    = PH_LOW;
                    st_d.cnt      = '0;
                    st_d.pull     = 1'b1;
                    st_d.lo_start = 1'b1;
                end
                PH_LOW: begin
                    if (lo_done) begin
                        st_d.phase = PH_WAIT_HI;
                        st_d.cnt   = '0;
                        st_d.pull  = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                PH_WAIT_HI: begin
                    if (line_hi_i) begin
                        st_d.phase    = PH_HIGH;
                        st_d.cnt      = '0;
                        st_d.hi_start = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (hi_done || cut_high) begin
                        st_d.phase    = PH_LOW;
                        st_d.cnt      = '0;
                        st_d.pull     = 1'b1;
                        st_d.lo_start = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.pull  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, pull: 1'b0, hi_start: 1'b0, lo_start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o     = st_q.pull;
    assign hi_start_o = st_q.hi_start;
    assign lo_start_o = st_q.lo_start;
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             sync_en_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             scl_i,
    output logic             scl_pull_o,
    output logic             hi_start_o,
    output logic             lo_start_o
);
    logic line_hi, line_fall;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_i),
        .level_o (line_hi),
        .fall_o  (line_fall)
    );

    scl_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_i),
        .sync_en_i   (sync_en_i),
        .hi_cnt_i    (hi_cnt_i),
        .lo_cnt_i    (lo_cnt_i),
        .line_hi_i   (line_hi),
        .line_fall_i (line_fall),
        .pull_o      (scl_pull_o),
        .hi_start_o  (hi_start_o),
        .lo_start_o  (lo_start_o)
    );
endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic run_i,
    input logic scl_pull_o,
    input logic hi_start_o,
    input logic lo_start_o
);
    a_r10_run_off_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !scl_pull_o);

    a_r9_starts_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({hi_start_o, lo_start_o}));

    a_r9_lo_start_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_start_o |-> scl_pull_o);

    a_r9_hi_start_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_start_o |-> !scl_pull_o);

    a_r2_pull_rise_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_pull_o) |-> lo_start_o);

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!hi_start_o && !lo_start_o));
endmodule

bind scl_clock_sync scl_clock_sync_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .scl_pull_o (scl_pull_o),
    .hi_start_o (hi_start_o),
    .lo_start_o (lo_start_o)
);

// File: tb/tb_scl_clock_sync.sv
module tb_scl_clock_sync;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {hi, lo, sync}
    localparam logic [16:0] VECS [NV] = '{
        {8'd3,  8'd5,  1'b0}, {8'd0,  8'd0,  1'b1}, {8'd1,  8'd1,  1'b0},
        {8'd10, 8'd2,  1'b1}, {8'd2,  8'd10, 1'b0}, {8'd0,  8'd7,  1'b1},
        {8'd20, 8'd20, 1'b1}, {8'd6,  8'd0,  1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, sync_en = 1'b0, ext_low = 1'b0;
    logic [7:0] hi_cnt = 8'd3, lo_cnt = 8'd3;
    logic pull, hi_start, lo_start;
    wire  scl_line = ~(pull | ext_low);
    int   n_vec = 0, n_bad = 0, overlap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clock_sync dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sync_en_i(sync_en),
        .hi_cnt_i(hi_cnt), .lo_cnt_i(lo_cnt), .scl_i(scl_line),
        .scl_pull_o(pull), .hi_start_o(hi_start), .lo_start_o(lo_start)
    );

    always @(negedge clk) if (rst_n && hi_start && lo_start) overlap++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    // Called at the negedge of the first cycle of a low phase; returns at the next one.
    task automatic measure(input int hi_e, input int lo_e);
        int lo_n = 0, rel_n = 0, hs_at = 0;
        while (pull && lo_n < 1000) begin lo_n++; @(negedge clk); end
        while (!pull && rel_n < 1000) begin
            rel_n++;
            if (hi_start && hs_at == 0) hs_at = rel_n;
            @(negedge clk);
        end
        chk(lo_n == lo_e + 1, "R3 low length", lo_n, lo_e + 1);
        chk(hs_at == 4, "R4 high start position", hs_at, 4);
        chk(rel_n == hi_e + 4, "R5 released length", rel_n, hi_e + 4);
    endtask

    task automatic restart(input logic [7:0] h, input logic [7:0] l, input logic s);
        @(negedge clk); run = 1'b0; ext_low = 1'b0;
        repeat (4) @(negedge clk);
        hi_cnt = h; lo_cnt = l; sync_en = s; run = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_hi_start();
        int g = 0;
        while (!hi_start && g < 2000) begin g++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int k;
        // R1: reset and idle
        repeat (3) @(negedge clk);
        chk(!pull && !hi_start && !lo_start, "R1 in reset", {pull, hi_start, lo_start}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pull && !hi_start && !lo_start, "R1 run off", {pull, hi_start, lo_start}, 0);

        // Table walk: R2..R5
        for (int i = 0; i < NV; i++) begin
            restart(VECS[i][16:9], VECS[i][8:1], VECS[i][0]);
            chk(pull && lo_start, "R2 first low start", {pull, lo_start}, 3);
            measure(eff(VECS[i][16:9]), eff(VECS[i][8:1]));
            chk(lo_start === 1'b1, "R2 low start after high", lo_start, 1);
            measure(eff(VECS[i][16:9]), eff(VECS[i][8:1]));
        end

        // R6: stretching by another device holding the line low
        restart(8'd4, 8'd3, 1'b1);
        ext_low = 1'b1;
        while (pull) @(negedge clk);
        k = 0;
        for (int j = 0; j < 20; j++) begin
            if (hi_start || pull) k++;
            @(negedge clk);
        end
        chk(k == 0, "R6 held while stretched", k, 0);
        ext_low = 1'b0;
        k = 0;
        while (!hi_start && k < 50) begin @(negedge clk); k++; end
        chk(k == 3, "R6 high start after free", k, 3);

        // R7: sync on, external fall cuts the high phase
        restart(8'd40, 8'd3, 1'b1);
        wait_hi_start();
        repeat (5) @(negedge clk);
        ext_low = 1'b1;
        k = 0;
        while (!pull && k < 100) begin @(negedge clk); k++; end
        chk(k == 3, "R7 cut reaction", k, 3);
        chk(lo_start === 1'b1, "R7 low start on cut", lo_start, 1);
        @(negedge clk); ext_low = 1'b0;

        // R8: sync off, external fall ignored
        restart(8'd40, 8'd3, 1'b0);
        wait_hi_start();
        k = 0;
        for (int j = 0; j < 5; j++) begin @(negedge clk); k++; end
        ext_low = 1'b1;
        @(negedge clk); k++;
        ext_low = 1'b0;
        while (!pull && k < 200) begin @(negedge clk); k++; end
        chk(k == 41, "R8 full high kept", k, 41);

        // R10: run drop mid low phase
        restart(8'd5, 8'd30, 1'b1);
        repeat (3) @(negedge clk);
        chk(pull === 1'b1, "R10 in low phase", pull, 1);
        run = 1'b0;
        @(negedge clk);
        chk(pull === 1'b0, "R10 released", pull, 0);
        chk(!hi_start && !lo_start, "R1 quiet after stop", {hi_start, lo_start}, 0);

        // R9: starts never overlap
        chk(overlap == 0, "R9 start overlap", overlap, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule